// File: doc/BRIEF.md
# Bus-to-DMA Window Address Translator

This block turns a 32-bit address seen on the peripheral bus into a 34-bit DMA address. Software programs four windows through a 64-bit register port. Each window has a match base, a size mask and a translated base. When a translation request arrives, the block searches the windows in a fixed priority order. It then either maps the address straight into the translated region, or uses the window in scatter-gather mode.

In scatter-gather mode the block forms the address of a 64-bit page-table entry and fetches that entry over a simple request/response memory interface. It then combines the page frame held in the entry with the low bits of the bus address. A request that no enabled window claims completes at once with a miss flag. Translation requests use a valid/ready handshake. Results come back as a one-cycle pulse.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset every window register reads as zero, `xl_ready` is high, and `res_valid` and `mem_req_valid` are low.
- R2: A register access answers with `reg_rsp_valid` exactly one cycle after `reg_valid`. The register index is (`reg_addr` − `BLOCK_BASE`) >> 6. Window w uses index 4w for its match base, 4w+1 for its size mask and 4w+2 for its translated base. A write takes effect for every later access and translation.
- R3: The port answers with `reg_rsp_err` high and `reg_rsp_rdata` zero, and changes no state, in each of these cases: `reg_size` is not 3 (3 means a 64-bit access), the address is below `BLOCK_BASE`, the index has the form 4w+3, or the index is above 17.
- R4: Index 16 (control) and index 17 (invalidate-all) accept writes without error, change no state, and always read as zero.
- R5: A window matches when the bus address and its match base agree on every bit in 30:20 whose size-mask bit is clear. Bus address bit 31 never affects matching.
- R6: Match-base bit 0 enables a window. A matching window with this bit clear is skipped.
- R7: When several enabled windows match, the lowest-numbered one produces the result.
- R8: When match-base bit 1 is clear (direct mode), let K = (mask & 0x7FF00000) | 0xFFFFF. The result is (translated base & ~K) | (bus address & K).
- R9: When match-base bit 1 is set (scatter-gather mode), let M = mask & 0x7FF00000. The block raises `mem_req_valid` the cycle after accepting the request, with `mem_req_addr` = (translated base & ~((M >> 10) | 0x3FF)) | ((bus address & (M | 0xFE000)) >> 10). It holds both signals steady until `mem_req_ready`.
- R10: The scatter-gather result is ((entry & ~1) << 12) | (bus address & 0x1FFF). Here entry is the 64-bit value on `mem_rsp_data`.
- R11: Every translated address and page-table address is truncated to its low 34 bits.
- R12: If no enabled window matches, `res_valid` pulses the cycle after acceptance with `res_miss` high and `res_addr` zero.
- R13: Direct results appear the cycle after acceptance. In scatter-gather mode, `xl_ready` stays low from acceptance until the result. A response counts only after the fetch request has been accepted, and the result appears the cycle after `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size code; 3 = 64-bit |
| reg_addr | input | 32 | Register access address |
| reg_wdata | input | 64 | Write data |
| reg_rsp_valid | output | 1 | Register response strobe |
| reg_rsp_err | output | 1 | Access rejected |
| reg_rsp_rdata | output | 64 | Read data |
| xl_valid | input | 1 | Translation request valid |
| xl_ready | output | 1 | Block can accept a request |
| xl_addr | input | 32 | Bus address to translate |
| res_valid | output | 1 | Result pulse |
| res_miss | output | 1 | No enabled window matched |
| res_addr | output | 34 | Translated DMA address |
| mem_req_valid | output | 1 | Page-table fetch request |
| mem_req_ready | input | 1 | Memory accepts fetch |
| mem_req_addr | output | 34 | Page-table entry address |
| mem_rsp_valid | input | 1 | Fetched entry valid |
| mem_rsp_data | input | 64 | Fetched page-table entry |

## Verification
The assertions assume the memory side never raises `mem_rsp_valid` except while a fetch is outstanding and its request has already been accepted. They also assume that at most one response arrives per fetch. The bench meets this by driving the response only after it has seen `mem_req_valid` drop following a `mem_req_ready` cycle, and by keeping the response high for a single cycle. Register accesses and translation requests are issued one at a time, each as a one-cycle strobe. This matches the checker's expectation that every register strobe is answered on the next cycle.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
    localparam int unsigned REG_W     = 64;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned REG_SHIFT = 6;
    localparam int unsigned IDX_SHIFT = 10;
    localparam int unsigned PG_SHIFT  = 12;

    localparam logic [REG_W-1:0] FIELD_MASK = 64'h0000_0000_7FF0_0000;
    localparam logic [REG_W-1:0] DIRECT_OFS = 64'h0000_0000_000F_FFFF;
    localparam logic [REG_W-1:0] PTE_LOW    = 64'h0000_0000_0000_03FF;
    localparam logic [REG_W-1:0] SG_IDX     = 64'h0000_0000_0000_7F << 13;
    localparam logic [REG_W-1:0] PAGE_OFS   = 64'h0000_0000_0000_1FFF;

    localparam logic [1:0] SIZE_DWORD = 2'd3;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] tbase;
    } win_cfg_t;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_REQ,
        XS_WAIT
    } xl_state_t;

    // combine a fetched page-table entry with the in-page bus offset
    function automatic logic [REG_W-1:0] sg_combine(input logic [REG_W-1:0] entry,
                                                     input logic [BUS_W-1:0] bus);
        logic [REG_W-1:0] frame;
        frame = (entry & ~64'h1) << PG_SHIFT;
        return frame | ({32'h0, bus} & PAGE_OFS);
    endfunction
endpackage

// File: rtl/pdx_regs.sv
module pdx_regs
    import pdx_pkg::*;
#(
    parameter int unsigned NWIN       = 4,
    parameter int unsigned ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BLOCK_BASE = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_valid,
    input  logic                   reg_write,
    input  logic [1:0]             reg_size,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [REG_W-1:0]       rsp_rdata,
    output win_cfg_t [NWIN-1:0]    win_o
);
    localparam int unsigned WIN_IW   = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam logic [ADDR_W-1:0] IDX_CTRL  = ADDR_W'(NWIN * 4);
    localparam logic [ADDR_W-1:0] IDX_INVAL = ADDR_W'(NWIN * 4 + 1);

    typedef struct packed {
        win_cfg_t [NWIN-1:0] win;
        logic                rsp_valid;
        logic                rsp_err;
        logic [REG_W-1:0]    rdata;
    } rf_t;

    rf_t st_d, st_q;

    logic [ADDR_W-1:0] diff, idx;
    logic [1:0]        kind;
    logic [WIN_IW-1:0] wsel;
    logic              below, in_win, is_ctrl, is_inval, legal;

    always_comb begin
        diff     = reg_addr - BLOCK_BASE;
        below    = reg_addr < BLOCK_BASE;
        idx      = diff >> REG_SHIFT;
        kind     = idx[1:0];
        wsel     = idx[2 +: WIN_IW];
        in_win   = (idx < IDX_CTRL) && (kind != 2'd3);
        is_ctrl  = idx == IDX_CTRL;
        is_inval = idx == IDX_INVAL;
        legal    = !below && (reg_size == SIZE_DWORD) && (in_win || is_ctrl || is_inval);

        st_d           = st_q;
        st_d.rsp_valid = reg_valid;
        st_d.rsp_err   = 1'b0;
        st_d.rdata     = '0;
        if (reg_valid) begin
            if (!legal) begin
                st_d.rsp_err = 1'b1;
            end else if (in_win) begin
                if (reg_write) begin
                    case (kind)
                        2'd0:    st_d.win[wsel].base  = reg_wdata;
                        2'd1:    st_d.win[wsel].mask  = reg_wdata;
                        default: st_d.win[wsel].tbase = reg_wdata;
                    endcase
                end else begin
                    case (kind)
                        2'd0:    st_d.rdata = st_q.win[wsel].base;
                        2'd1:    st_d.rdata = st_q.win[wsel].mask;
                        default: st_d.rdata = st_q.win[wsel].tbase;
                    endcase
                end
            end
            // control and invalidate-all: accepted, read zero, no effect
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rdata;
    assign win_o     = st_q.win;
endmodule

// File: rtl/pdx_win_sel.sv
module pdx_win_sel
    import pdx_pkg::*;
#(
    parameter int unsigned NWIN = 4
) (
    input  win_cfg_t [NWIN-1:0] win,
    input  logic [BUS_W-1:0]    bus_addr,
    output logic                hit,
    output win_cfg_t            sel
);
    logic [NWIN-1:0] claim;

    for (genvar i = 0; i < NWIN; i++) begin : g_match
        logic [REG_W-1:0] cmp;
        assign cmp      = ~win[i].mask & FIELD_MASK;
        assign claim[i] = win[i].base[0] &&
                          ((({32'h0, bus_addr}) & cmp) == (win[i].base & cmp));
    end

    always_comb begin
        hit = |claim;
        sel = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (claim[i]) sel = win[i];
        end
    end
endmodule

// File: rtl/pdx_addr_calc.sv
module pdx_addr_calc
    import pdx_pkg::*;
#(
    parameter int unsigned DMA_W = 34
) (
    input  win_cfg_t           sel,
    input  logic [BUS_W-1:0]   bus_addr,
    output logic [DMA_W-1:0]   direct_addr,
    output logic [DMA_W-1:0]   pte_addr
);
    logic [REG_W-1:0] bus64, field, keep, full_direct, full_pte;

    always_comb begin
        bus64       = {32'h0, bus_addr};
        field       = sel.mask & FIELD_MASK;
        keep        = field | DIRECT_OFS;
        full_direct = (sel.tbase & ~keep) | (bus64 & keep);
        full_pte    = (sel.tbase & ~((field >> IDX_SHIFT) | PTE_LOW))
                    | ((bus64 & (field | SG_IDX)) >> IDX_SHIFT);
        direct_addr = full_direct[DMA_W-1:0];
        pte_addr    = full_pte[DMA_W-1:0];
    end
endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
    import pdx_pkg::*;
#(
    parameter int unsigned NWIN   = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DMA_W  = 34,
    parameter logic [ADDR_W-1:0] BLOCK_BASE = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [1:0]        reg_size,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic              reg_rsp_valid,
    output logic              reg_rsp_err,
    output logic [63:0]       reg_rsp_rdata,
    input  logic              xl_valid,
    output logic              xl_ready,
    input  logic [31:0]       xl_addr,
    output logic              res_valid,
    output logic              res_miss,
    output logic [DMA_W-1:0]  res_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DMA_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    typedef struct packed {
        xl_state_t        state;
        logic [BUS_W-1:0] bus;
        logic [DMA_W-1:0] pte;
        logic             rvalid;
        logic             rmiss;
        logic [DMA_W-1:0] raddr;
    } xl_t;

    xl_t xs_d, xs_q;

    win_cfg_t [NWIN-1:0] win;
    win_cfg_t            sel;
    logic                hit;
    logic [DMA_W-1:0]    direct_addr, pte_addr;
    logic [REG_W-1:0]    sg_full;

    pdx_regs #(.NWIN(NWIN), .ADDR_W(ADDR_W), .BLOCK_BASE(BLOCK_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_size  (reg_size),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rsp_valid (reg_rsp_valid),
        .rsp_err   (reg_rsp_err),
        .rsp_rdata (reg_rsp_rdata),
        .win_o     (win)
    );

    pdx_win_sel #(.NWIN(NWIN)) u_sel (
        .win      (win),
        .bus_addr (xl_addr),
        .hit      (hit),
        .sel      (sel)
    );

    pdx_addr_calc #(.DMA_W(DMA_W)) u_calc (
        .sel         (sel),
        .bus_addr    (xl_addr),
        .direct_addr (direct_addr),
        .pte_addr    (pte_addr)
    );

    always_comb begin
        sg_full     = sg_combine(mem_rsp_data, xs_q.bus);
        xs_d        = xs_q;
        xs_d.rvalid = 1'b0;
        xs_d.rmiss  = 1'b0;
        xs_d.raddr  = '0;
        case (xs_q.state)
            XS_IDLE: begin
                if (xl_valid) begin
                    if (!hit) begin
                        xs_d.rvalid = 1'b1;
                        xs_d.rmiss  = 1'b1;
                    end else if (!sel.base[1]) begin
                        xs_d.rvalid = 1'b1;
                        xs_d.raddr  = direct_addr;
                    end else begin
                        xs_d.state = XS_REQ;
                        xs_d.bus   = xl_addr;
                        xs_d.pte   = pte_addr;
                    end
                end
            end
            XS_REQ: begin
                if (mem_req_ready) xs_d.state = XS_WAIT;
            end
            XS_WAIT: begin
                if (mem_rsp_valid) begin
                    xs_d.rvalid = 1'b1;
                    xs_d.raddr  = sg_full[DMA_W-1:0];
                    xs_d.state  = XS_IDLE;
                end
            end
            default: xs_d.state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xs_q <= '{state: XS_IDLE, default: '0};
        else        xs_q <= xs_d;
    end

    assign xl_ready      = xs_q.state == XS_IDLE;
    assign mem_req_valid = xs_q.state == XS_REQ;
    assign mem_req_addr  = xs_q.pte;
    assign res_valid     = xs_q.rvalid;
    assign res_miss      = xs_q.rmiss;
    assign res_addr      = xs_q.raddr;
endmodule

// File: rtl/pdx_checker.sv
module pdx_checker #(
    parameter int unsigned DMA_W = 34
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_valid,
    input logic             reg_rsp_valid,
    input logic             reg_rsp_err,
    input logic [63:0]      reg_rsp_rdata,
    input logic             xl_ready,
    input logic             res_valid,
    input logic             res_miss,
    input logic [DMA_W-1:0] res_addr,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [DMA_W-1:0] mem_req_addr,
    input logic             mem_rsp_valid
);
    AST_REG_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid |=> reg_rsp_valid); // R2
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rsp_valid && reg_rsp_err) |-> (reg_rsp_rdata == '0)); // R3
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_addr == '0)); // R12
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !xl_ready); // R13
    AST_RESULT_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!xl_ready && !mem_req_valid && mem_rsp_valid) |=> (res_valid && !res_miss && xl_ready)); // R13
endmodule

bind pci_dma_xlate pdx_checker #(.DMA_W(DMA_W)) u_pdx_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_valid     (reg_valid),
    .reg_rsp_valid (reg_rsp_valid),
    .reg_rsp_err   (reg_rsp_err),
    .reg_rsp_rdata (reg_rsp_rdata),
    .xl_ready      (xl_ready),
    .res_valid     (res_valid),
    .res_miss      (res_miss),
    .res_addr      (res_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/pci_dma_xlate_test.sv
module pci_dma_xlate_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_size = 2'd3;
    logic [31:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_rsp_valid, reg_rsp_err;
    logic [63:0] reg_rsp_rdata;
    logic        xl_valid = 1'b0, xl_ready;
    logic [31:0] xl_addr = '0;
    logic        res_valid, res_miss;
    logic [33:0] res_addr;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pci_dma_xlate #(.BLOCK_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rsp_valid(reg_rsp_valid), .reg_rsp_err(reg_rsp_err), .reg_rsp_rdata(reg_rsp_rdata),
        .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_addr(xl_addr),
        .res_valid(res_valid), .res_miss(res_miss), .res_addr(res_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] ra(input int idx);
        return BASE + 32'(idx * 64);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_acc(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                           input logic [63:0] wd, output bit err, output logic [63:0] rd);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_size = sz; reg_addr = addr; reg_wdata = wd;
        @(negedge clk);
        reg_valid = 1'b0;
        check(reg_rsp_valid === 1'b1, "R2 response strobe", 64'(reg_rsp_valid), 64'd1);
        err = reg_rsp_err;
        rd  = reg_rsp_rdata;
    endtask

    task automatic wr_reg(input int idx, input logic [63:0] v);
        bit e; logic [63:0] r;
        reg_acc(1'b1, 2'd3, ra(idx), v, e, r);
        check(e == 1'b0, "R2 write accepted", 64'(e), 64'd0);
    endtask

    task automatic rd_check(input int idx, input logic [63:0] exp, input string req);
        bit e; logic [63:0] r;
        reg_acc(1'b0, 2'd3, ra(idx), '0, e, r);
        check(!e && r === exp, req, r, exp);
    endtask

    task automatic xl_check(input logic [31:0] bus, input logic [33:0] exp, input bit miss, input string req);
        @(negedge clk);
        check(xl_ready === 1'b1, "R13 ready before request", 64'(xl_ready), 64'd1);
        xl_valid = 1'b1; xl_addr = bus;
        @(negedge clk);
        xl_valid = 1'b0;
        check(res_valid === 1'b1 && res_miss === miss && res_addr === exp, req,
              {29'h0, res_valid, res_miss, res_addr}, {29'h0, 1'b1, miss, exp});
    endtask

    task automatic test_reset();
        check(xl_ready === 1'b1 && res_valid === 1'b0 && mem_req_valid === 1'b0, "R1 idle outputs",
              {61'h0, xl_ready, res_valid, mem_req_valid}, 64'h4);
        for (int i = 0; i < 12; i++) rd_check((i / 3) * 4 + (i % 3), 64'h0, "R1 register zero");
    endtask

    task automatic test_regs();
        wr_reg(5, 64'hDEAD_BEEF_0030_0000);
        rd_check(5, 64'hDEAD_BEEF_0030_0000, "R2 readback mask1");
        wr_reg(5, 64'h0000_0000_0030_0000);
        rd_check(5, 64'h0000_0000_0030_0000, "R2 readback rewrite");
    endtask

    task automatic test_errors();
        bit e; logic [63:0] r;
        wr_reg(0, 64'h4000_0001);
        reg_acc(1'b1, 2'd2, ra(0), 64'h5555, e, r);
        check(e && r == 0, "R3 wrong size write", {63'h0, e}, 64'd1);
        rd_check(0, 64'h4000_0001, "R3 no state change on bad size");
        reg_acc(1'b0, 2'd1, ra(0), '0, e, r);
        check(e && r == 0, "R3 wrong size read", r, 64'd0);
        reg_acc(1'b1, 2'd3, ra(3), 64'h1, e, r);
        check(e == 1'b1, "R3 hole index", {63'h0, e}, 64'd1);
        reg_acc(1'b0, 2'd3, ra(18), '0, e, r);
        check(e == 1'b1, "R3 index above range", {63'h0, e}, 64'd1);
        reg_acc(1'b1, 2'd3, BASE - 32'd64, 64'h1, e, r);
        check(e == 1'b1, "R3 below base", {63'h0, e}, 64'd1);
    endtask

    task automatic test_ctrl();
        bit e; logic [63:0] r;
        reg_acc(1'b1, 2'd3, ra(16), 64'hFFFF_FFFF, e, r);
        check(e == 1'b0, "R4 control write accepted", {63'h0, e}, 64'd0);
        rd_check(16, 64'h0, "R4 control reads zero");
        reg_acc(1'b1, 2'd3, ra(17), 64'h1234, e, r);
        check(e == 1'b0, "R4 invalidate write accepted", {63'h0, e}, 64'd0);
        rd_check(17, 64'h0, "R4 invalidate reads zero");
        rd_check(0, 64'h4000_0001, "R4 window state untouched");
    endtask

    task automatic test_direct();
        wr_reg(0, 64'h4000_0001);
        wr_reg(1, 64'h0);
        wr_reg(2, 64'h2_ABC0_0000);
        xl_check(32'h4001_2345, 34'h2_ABC1_2345, 1'b0, "R8 direct window0");
        xl_check(32'hC001_2345, 34'h2_ABC1_2345, 1'b0, "R5 bit31 ignored");
        wr_reg(4, 64'h0800_0001);
        wr_reg(6, 64'h1_2340_0000);
        xl_check(32'h0833_4567, 34'h1_2373_4567, 1'b0, "R5 R8 masked size window1");
        wr_reg(8, 64'h2000_0001);
        wr_reg(10, 64'hFFFF_FFFF_C000_0000);
        xl_check(32'h2005_5555, 34'h3_C005_5555, 1'b0, "R11 direct truncation");
        xl_check(32'h7FF0_0000, 34'h0, 1'b1, "R12 miss");
    endtask

    task automatic test_priority();
        wr_reg(12, 64'h4000_0001);
        wr_reg(14, 64'h1110_0000);
        xl_check(32'h4001_2345, 34'h2_ABC1_2345, 1'b0, "R7 lowest window wins");
        wr_reg(0, 64'h4000_0000);
        xl_check(32'h4001_2345, 34'h0_1111_2345, 1'b0, "R6 disabled window skipped");
        wr_reg(12, 64'h4000_0000);
        xl_check(32'h4001_2345, 34'h0, 1'b1, "R6 R12 all disabled miss");
    endtask

    task automatic sg_run(input logic [31:0] bus, input logic [33:0] exp_pte,
                          input logic [63:0] entry, input logic [33:0] exp, input string req);
        @(negedge clk);
        xl_valid = 1'b1; xl_addr = bus;
        @(negedge clk);
        xl_valid = 1'b0;
        check(mem_req_valid === 1'b1 && mem_req_addr === exp_pte, "R9 fetch address",
              {30'h0, mem_req_addr}, {30'h0, exp_pte});
        check(xl_ready === 1'b0 && res_valid === 1'b0, "R13 busy during fetch",
              {62'h0, xl_ready, res_valid}, 64'h0);
        @(negedge clk);
        check(mem_req_valid === 1'b1 && mem_req_addr === exp_pte, "R9 request held",
              {30'h0, mem_req_addr}, {30'h0, exp_pte});
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid === 1'b0 && xl_ready === 1'b0, "R13 waiting for entry",
              {62'h0, mem_req_valid, xl_ready}, 64'h0);
        @(negedge clk);
        check(res_valid === 1'b0, "R13 no early result", 64'(res_valid), 64'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = entry;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(res_valid === 1'b1 && res_miss === 1'b0 && res_addr === exp, req,
              {30'h0, res_addr}, {30'h0, exp});
        check(xl_ready === 1'b1, "R13 ready after result", 64'(xl_ready), 64'd1);
    endtask

    task automatic test_sg();
        wr_reg(8, 64'h2000_0003);
        wr_reg(9, 64'h0010_0000);
        wr_reg(10, 64'h0012_3000);
        sg_run(32'h2013_6789, 34'h0_0012_34D8, 64'h000A_BCD1, 34'h0_ABCD_0789, "R10 scatter-gather result");
        sg_run(32'h2013_6789, 34'h0_0012_34D8, 64'h0000_0FFF_FFFF_FFFF, 34'h3_FFFF_E789, "R11 R10 truncated frame");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_regs();
        test_errors();
        test_ctrl();
        test_direct();
        test_priority();
        test_sg();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule